// File: doc/BRIEF.md
# Delayed-Branch Fetch Address Sequencer

This block produces the instruction fetch address for a small pipelined core whose jumps, calls and returns can be delayed. Each cycle the decoder reports what the instruction at the current fetch address does: a branch with its target, a call with its target, a return, and a qualifier that marks the transfer as delayed or immediate. A stall input holds the whole sequencer.

A delayed transfer does not redirect at once. The sequencer keeps fetching sequential addresses for `N_SLOTS` more instructions, which are the delay slots, and only then jumps. A delayed call saves a return address that lies past its own delay slots, so that control comes back after instructions that have already run, and no address is fetched twice. Return addresses are kept on a small internal stack. The stack reports overflow and underflow and does not wrap. A transfer that turns up inside the delay slots of another transfer is refused and reported.

`N_SLOTS` is a compile-time value from 0 to 3. With 0, every transfer behaves as an immediate one.

Top module: `dbs_fetch_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr_o` is 0 and `fetch_vld_o` is 0. After reset no redirect is pending and the return stack is empty. Reset is released through two synchronizing flops, and the sequencer stays idle until that release has passed through them.
- R2: With no transfer requested and no stall, `fetch_vld_o` is 1 and the fetch address goes up by 1 on every cycle.
- R3: A delayed branch fetched at address A makes the next fetches A+1 … A+N_SLOTS, followed by the branch target.
- R4: A delayed call at address A pushes A+1+N_SLOTS, fetches its N_SLOTS delay slots, and then fetches the call target.
- R5: A delayed return fetches its N_SLOTS delay slots and then fetches the most recently pushed address. Returns pop addresses in last-in, first-out order.
- R6: An immediate transfer (`dly_i`=0) redirects on the very next fetch. An immediate call at address A pushes A+1.
- R7: A branch, call or return requested while delay slots are still being fetched drives `xfer_err_o` high in that same cycle. It has no effect on the fetch stream or on the stack.
- R8: A call made while the stack already holds `RAS_DEPTH` entries drives `ras_ovf_o` high in that cycle. The call is dropped: nothing is pushed and fetching continues sequentially.
- R9: A return made while the stack is empty drives `ras_unf_o` high in that cycle. The return is dropped and fetching continues sequentially.
- R10: While `stall_i` is high, `fetch_vld_o` is 0. The fetch address, the remaining-slot count and the stack all hold, control inputs are ignored, and all three flags stay low.
- R11: When several transfers are requested at once, a call takes precedence over a return, and a return takes precedence over a branch. Only the winner acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall_i | input | 1 | Freezes the sequencer |
| br_i | input | 1 | Instruction at the fetch address is a branch |
| br_tgt_i | input | ADDR_W | Branch target |
| call_i | input | 1 | Instruction at the fetch address is a call |
| call_tgt_i | input | ADDR_W | Call target |
| ret_i | input | 1 | Instruction at the fetch address is a return |
| dly_i | input | 1 | 1 = transfer is delayed by N_SLOTS, 0 = immediate |
| fetch_addr_o | output | ADDR_W | Current fetch address |
| fetch_vld_o | output | 1 | Fetch address is issued this cycle |
| xfer_err_o | output | 1 | Transfer requested inside delay slots (refused) |
| ras_ovf_o | output | 1 | Call refused because the return stack is full |
| ras_unf_o | output | 1 | Return refused because the return stack is empty |

## Verification
The bench builds the block with two delay slots and a return stack only four entries deep. Two slots make the gap between the call address and the pushed return address visible, and they leave a middle slot in which a second transfer can be tried. The shallow stack lets a short nested-call chain reach overflow, followed by unwinding in LIFO order. A stall placed inside a return's delay slots shows that the slot count is frozen along with the address.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // Winning transfer request in the current cycle
  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_BR   = 2'd1,
    XF_CALL = 2'd2,
    XF_RET  = 2'd3
  } xfer_e;

endpackage

// File: rtl/dbs_ret_stack.sv
module dbs_ret_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] top_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [SP_W-1:0] sp_q, sp_d;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign wr_idx  = IDX_W'(sp_q);
  assign rd_idx  = IDX_W'(sp_q - SP_W'(1));
  assign top_o   = empty_o ? '0 : mem[rd_idx];

  always_comb begin
    sp_d = sp_q;
    if (push_i)     sp_d = sp_q + SP_W'(1);
    else if (pop_i) sp_d = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_idx] <= push_data_i;
  end

  // R8: the caller must never push onto a full stack
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R9: the caller must never pop an empty stack
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/dbs_slot_ctl.sv
module dbs_slot_ctl #(
  parameter int AW      = 16,
  parameter int N_SLOTS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic [AW-1:0] tgt_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [AW-1:0] tgt_o
);

  localparam int CW = 2;

  generate
    if (N_SLOTS == 0) begin : g_none
      assign busy_o = 1'b0;
      assign last_o = 1'b0;
      assign tgt_o  = tgt_i;
    end else begin : g_slots
      logic [CW-1:0] cnt_q, cnt_d;
      logic [AW-1:0] tgt_q, tgt_d;

      assign busy_o = (cnt_q != '0);
      assign last_o = (cnt_q == CW'(1));
      assign tgt_o  = tgt_q;

      always_comb begin
        cnt_d = cnt_q;
        tgt_d = tgt_q;
        if (load_i) begin
          cnt_d = CW'(N_SLOTS);
          tgt_d = tgt_i;
        end else if (adv_i && busy_o) begin
          cnt_d = cnt_q - CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          tgt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
          tgt_q <= tgt_d;
        end
      end

      // R7: a new delayed transfer is never armed while slots remain
      assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);
    end
  endgenerate

endmodule

// File: rtl/dbs_fetch_seq.sv
module dbs_fetch_seq #(
  parameter int ADDR_W    = 16,
  parameter int N_SLOTS   = 2,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              br_i,
  input  logic [ADDR_W-1:0] br_tgt_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_tgt_i,
  input  logic              ret_i,
  input  logic              dly_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_vld_o,
  output logic              xfer_err_o,
  output logic              ras_ovf_o,
  output logic              ras_unf_o
);
  import dbs_pkg::*;

  localparam logic [ADDR_W-1:0] STEP_DLY = ADDR_W'(N_SLOTS + 1);
  localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
  localparam bit HAS_SLOTS = (N_SLOTS > 0);

  logic [1:0]        rst_sync_q;
  logic              run;
  logic              act;
  logic [ADDR_W-1:0] pc_q, pc_d;

  logic              slot_busy, slot_last, slot_load;
  logic [ADDR_W-1:0] slot_tgt;
  logic              ras_full, ras_empty, ras_push, ras_pop;
  logic [ADDR_W-1:0] ras_top, push_val;

  xfer_e             req, win;
  logic              delayed;
  logic [ADDR_W-1:0] xfer_tgt;

  // reset release synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run = rst_sync_q[1];
  assign act = run & ~stall_i;

  // request priority: call, then return, then branch
  always_comb begin
    if (call_i)     req = XF_CALL;
    else if (ret_i) req = XF_RET;
    else if (br_i)  req = XF_BR;
    else            req = XF_NONE;
  end

  // acceptance and fault reporting
  always_comb begin
    win        = XF_NONE;
    xfer_err_o = 1'b0;
    ras_ovf_o  = 1'b0;
    ras_unf_o  = 1'b0;
    if (act && req != XF_NONE) begin
      if (slot_busy)                         xfer_err_o = 1'b1;
      else if (req == XF_CALL && ras_full)   ras_ovf_o  = 1'b1;
      else if (req == XF_RET  && ras_empty)  ras_unf_o  = 1'b1;
      else                                   win        = req;
    end
  end

  assign delayed  = HAS_SLOTS && dly_i;
  assign push_val = pc_q + (delayed ? STEP_DLY : STEP_ONE);
  assign ras_push = (win == XF_CALL);
  assign ras_pop  = (win == XF_RET);

  always_comb begin
    unique case (win)
      XF_CALL: xfer_tgt = call_tgt_i;
      XF_RET:  xfer_tgt = ras_top;
      XF_BR:   xfer_tgt = br_tgt_i;
      default: xfer_tgt = '0;
    endcase
  end

  assign slot_load = (win != XF_NONE) && delayed;

  // next fetch address
  always_comb begin
    pc_d = pc_q;
    if (act) begin
      if (slot_busy && slot_last)             pc_d = slot_tgt;
      else if (win != XF_NONE && !delayed)    pc_d = xfer_tgt;
      else                                    pc_d = pc_q + STEP_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign fetch_vld_o  = act;

  dbs_slot_ctl #(
    .AW      (ADDR_W),
    .N_SLOTS (N_SLOTS)
  ) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (act),
    .load_i (slot_load),
    .tgt_i  (xfer_tgt),
    .busy_o (slot_busy),
    .last_o (slot_last),
    .tgt_o  (slot_tgt)
  );

  dbs_ret_stack #(
    .DW    (ADDR_W),
    .DEPTH (RAS_DEPTH)
  ) u_ras (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ras_push),
    .push_data_i (push_val),
    .pop_i       (ras_pop),
    .top_o       (ras_top),
    .full_o      (ras_full),
    .empty_o     (ras_empty)
  );

  // R10: a stalled cycle leaves the fetch address untouched
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(fetch_addr_o));
  // R3: the last delay slot is followed by the stored target
  assert_slot_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && slot_busy && slot_last) |=> (fetch_addr_o == $past(slot_tgt)));
  // R7: a refused transfer never also reports a stack fault
  assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_o |-> !(ras_ovf_o || ras_unf_o));
  // R10: flags are silent while stalled
  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !(xfer_err_o || ras_ovf_o || ras_unf_o || fetch_vld_o));

endmodule

// File: tb/dbs_fetch_seq_tb.sv
`timescale 1ns/1ps
module dbs_fetch_seq_tb;

  localparam int AW = 16;
  localparam int NS = 2;
  localparam int RD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall_i = 1'b0, br_i = 1'b0, call_i = 1'b0, ret_i = 1'b0, dly_i = 1'b0;
  logic [AW-1:0] br_tgt_i = '0, call_tgt_i = '0;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_vld_o, xfer_err_o, ras_ovf_o, ras_unf_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural model state
  int m_pc = 0;
  int m_left = 0;
  int m_tgt = 0;
  int m_stack[$];

  always #2.5 clk = ~clk;

  dbs_fetch_seq #(.ADDR_W(AW), .N_SLOTS(NS), .RAS_DEPTH(RD)) u_dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
    .br_i(br_i), .br_tgt_i(br_tgt_i), .call_i(call_i), .call_tgt_i(call_tgt_i),
    .ret_i(ret_i), .dly_i(dly_i),
    .fetch_addr_o(fetch_addr_o), .fetch_vld_o(fetch_vld_o),
    .xfer_err_o(xfer_err_o), .ras_ovf_o(ras_ovf_o), .ras_unf_o(ras_unf_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one fetch cycle: drive at negedge, compare, advance the model
  task automatic step(input string req, input bit s, input bit b, input bit c,
                      input bit r, input bit d, input int bt, input int ct);
    bit e_err, e_ovf, e_unf;
    int nxt;
    stall_i = s; br_i = b; call_i = c; ret_i = r; dly_i = d;
    br_tgt_i = AW'(bt); call_tgt_i = AW'(ct);
    #1;
    e_err = 0; e_ovf = 0; e_unf = 0;
    nxt = m_pc;
    if (!s) begin
      nxt = m_pc + 1;
      if (m_left > 0) begin
        if (b || c || r) e_err = 1;
        if (m_left == 1) nxt = m_tgt;
        m_left--;
      end else if (c) begin
        if (m_stack.size() == RD) e_ovf = 1;
        else begin
          m_stack.push_back(d ? m_pc + 1 + NS : m_pc + 1);
          if (d) begin m_left = NS; m_tgt = ct; end else nxt = ct;
        end
      end else if (r) begin
        if (m_stack.size() == 0) e_unf = 1;
        else begin
          int ra;
          ra = m_stack.pop_back();
          if (d) begin m_left = NS; m_tgt = ra; end else nxt = ra;
        end
      end else if (b) begin
        if (d) begin m_left = NS; m_tgt = bt; end else nxt = bt;
      end
    end
    chk(req, "fetch_addr", int'(fetch_addr_o), m_pc);
    chk(req, "fetch_vld", int'(fetch_vld_o), s ? 0 : 1);
    chk(req, "xfer_err", int'(xfer_err_o), int'(e_err));
    chk(req, "ras_ovf", int'(ras_ovf_o), int'(e_ovf));
    chk(req, "ras_unf", int'(ras_unf_o), int'(e_unf));
    m_pc = nxt;
    @(negedge clk);
  endtask

  task automatic idle(input string req);
    step(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "fetch_addr", int'(fetch_addr_o), 0);
    chk("R1", "fetch_vld", int'(fetch_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "vld_sync", int'(fetch_vld_o), 0);
    repeat (3) step("R1", 1, 0, 0, 0, 0, 0, 0);

    // R4 delayed call 0 -> 10, return lands at 3
    step("R4", 0, 0, 1, 0, 1, 0, 10);
    idle("R4"); idle("R4");
    // R5 delayed return
    step("R5", 0, 0, 0, 1, 1, 0, 0);
    idle("R5"); idle("R5");
    // R3 delayed branch at 3 -> 20
    step("R3", 0, 1, 0, 0, 1, 20, 0);
    idle("R3"); idle("R3");
    // R6 immediate branch, call, return
    step("R6", 0, 1, 0, 0, 0, 30, 0);
    step("R6", 0, 0, 1, 0, 0, 0, 40);
    step("R6", 0, 0, 0, 1, 0, 0, 0);
    // R7 transfers inside slots
    step("R7", 0, 1, 0, 0, 1, 50, 0);
    step("R7", 0, 1, 0, 0, 0, 99, 0);
    step("R7", 0, 0, 1, 1, 1, 0, 77);
    // R10 stall with requests present
    step("R10", 1, 1, 1, 1, 0, 5, 6);
    step("R10", 1, 0, 0, 1, 1, 0, 0);
    idle("R2"); idle("R2");
    // R9 underflow
    step("R9", 0, 0, 0, 1, 0, 0, 0);
    idle("R2");
    // R8 fill stack, then overflow
    step("R8", 0, 0, 1, 0, 0, 0, 60);
    step("R8", 0, 0, 1, 0, 0, 0, 70);
    step("R8", 0, 0, 1, 0, 0, 0, 80);
    step("R8", 0, 0, 1, 0, 0, 0, 90);
    step("R8", 0, 0, 1, 0, 1, 0, 100);
    step("R8", 0, 1, 1, 0, 0, 111, 110);
    // R5 LIFO unwind with delayed return
    step("R5", 0, 0, 0, 1, 1, 0, 0);
    idle("R5"); idle("R5");
    // R11 return beats branch
    step("R11", 0, 1, 0, 1, 0, 200, 0);
    // R11 call beats return and branch
    step("R11", 0, 1, 1, 1, 0, 210, 130);
    // R10 stall inside delayed return slots
    step("R10", 0, 0, 0, 1, 1, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    idle("R10"); idle("R10");
    // R2 plain run
    repeat (4) idle("R2");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule